// File: doc/BRIEF.md
# Upper-Half Lane Controller for a 64-bit Multiplexed Address/Data Bus

This block looks after the upper 32 bits of a 64-bit multiplexed address/data bus on one port of a bus bridge. It decides, cycle by cycle, whether the upper address/data lines and the upper four command/byte-enable lines are driven. It parks them at a fixed level when the bus is idle and this port holds the grant. It drives the 64-bit request and acknowledge handshake lines with the required one-cycle high release. It also generates the parity bit for the upper half and checks it.

Parity for the upper half is always registered. It follows the lines it covers by one clock, and its output enable trails the address/data enable by the same clock. At reset the block samples the request-64 line as a strap. A low level enables wide operation. A high level means nothing is attached to the upper half, so the block keeps those lines driven at zero from then on. The surrounding bridge supplies the transaction role (initiator or target), the direction, whether the command is a dual-address one, and whether it wants or accepts a wide transfer. Bus control inputs are sampled pin levels and are active low.

Top module: `upper_lane_top`

## Requirements
- R1: While `rstN` is low, `wide64` takes the inverse of `req64In` at each clock edge. From the release of reset until the next reset it holds the value captured at the last reset edge.
- R2: While `rstN` is low, `adOe`, `cbeOe`, `req64Oe` and `ack64Oe` are all 0. The registered outputs `parOe` and `perr` are 0 after any clock edge taken in reset.
- R3: After each edge out of reset, `parOut` equals the XOR of all bits of `adIn` and `cbeIn` from the cycle before (even parity). `parOe` equals the value `adOe` had in that cycle.
- R4: With `wide64` = 0 and reset released, `adOe` and `cbeOe` are 1 and `adOut` and `cbeOut` are all zero in every cycle. `req64Oe` and `ack64Oe` stay 0.
- R5: When `frameN` and `irdyN` are both 1 (idle) and `gntN` is 0, `adOe` and `cbeOe` are 1 and `adOut` and `cbeOut` are zero.
- R6: An address phase is the first cycle with `frameN` 0 after a cycle with `frameN` 1. If `dualAddr` is 1 in that cycle, the cycle after it is a second address phase. In either phase, when `isInit` and `localReq64` are 1, `adOe` and `cbeOe` are 1 and `adOut`/`cbeOut` carry `txAd`/`txCbe`.
- R7: A data phase is any non-address cycle that is not idle, and it is wide when `req64In` and `ack64In` are both 0. A wide data phase is driven from `txAd`/`txCbe` as follows: on a write (`isWrite` 1) the initiator drives AD and CBE; on a read the initiator drives CBE only and the target drives AD. A data phase that is not wide drives neither.
- R8: With `wide64` 1, `req64Out` is 0 and `req64Oe` is 1 in every cycle where `isInit`, `localReq64` are 1 and `frameN` is 0. In the cycle after the last such cycle, `req64Out` is 1 with `req64Oe` 1. In the cycle after that, `req64Oe` is 0 unless it asserts again.
- R9: With `wide64` 1, `ack64Out` is 0 and `ack64Oe` is 1 in every cycle where `isTarget`, `localAck64` are 1 and `devselN` and `req64In` are 0. The release follows the same one-cycle-high rule as R8.
- R10: A receive cycle is one of two cases with `wide64` 1. The first is an address phase seen as target with `req64In` 0. The second is a wide data phase with `irdyN` and `trdyN` both 0 in which the other party drives AD: a read for the initiator or a write for the target. If `parIn` in the next cycle differs from that cycle's parity, `perr` is 1 for exactly the one cycle after that; otherwise `perr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| frameN | input | 1 | Sampled cycle-frame line, active low |
| irdyN | input | 1 | Sampled initiator-ready line, active low |
| trdyN | input | 1 | Sampled target-ready line, active low |
| devselN | input | 1 | Sampled device-select line, active low |
| gntN | input | 1 | Bus grant to this port, active low |
| req64In | input | 1 | Sampled 64-bit request line; strap during reset |
| ack64In | input | 1 | Sampled 64-bit acknowledge line |
| isInit | input | 1 | This port is the initiator of the current transaction |
| isTarget | input | 1 | This port is the target of the current transaction |
| isWrite | input | 1 | Current transaction is a write |
| dualAddr | input | 1 | Current command uses two address phases |
| localReq64 | input | 1 | Initiator side asks for a wide transfer |
| localAck64 | input | 1 | Target side accepts a wide transfer |
| txAd | input | 32 | Upper address/data value to drive |
| txCbe | input | 4 | Upper command/byte-enable value to drive |
| adIn | input | 32 | Sampled upper address/data lines |
| cbeIn | input | 4 | Sampled upper command/byte-enable lines |
| parIn | input | 1 | Sampled upper parity line |
| adOut | output | 32 | Driven upper address/data value |
| adOe | output | 1 | Output enable for upper address/data |
| cbeOut | output | 4 | Driven upper command/byte-enable value |
| cbeOe | output | 1 | Output enable for upper command/byte enables |
| parOut | output | 1 | Driven upper parity value |
| parOe | output | 1 | Output enable for upper parity |
| req64Out | output | 1 | Driven 64-bit request value |
| req64Oe | output | 1 | Output enable for 64-bit request |
| ack64Out | output | 1 | Driven 64-bit acknowledge value |
| ack64Oe | output | 1 | Output enable for 64-bit acknowledge |
| perr | output | 1 | One-cycle upper-parity error pulse |
| wide64 | output | 1 | Latched wide-operation capability |

## Verification
The properties assume that the strap level on `req64In` is the one present at the last reset edge, and that the bus control inputs are clean 0/1 levels in every cycle. The release and parking checks also assume that the role inputs do not mark the port as initiator and target at once. The stimulus draws `isTarget` as the complement of `isInit` so that the two roles never overlap. It changes inputs only on the falling clock edge. Everything else is left free: frame, ready, select, grant and the handshake lines are drawn at random with biased weights so that address, data, idle and release cycles all occur. `parIn` is set to the correct parity or its complement at random.

// File: rtl/upper_lane_pkg.sv
package upper_lane_pkg;

  // strobes from control to datapath, valid within the current cycle
  typedef struct packed {
    logic zeroLane;   // drive zeros (parking or narrow strap)
    logic drvAd;      // upper address/data enable
    logic drvCbe;     // upper command/byte-enable enable
    logic rxArm;      // this cycle's bus value must be parity-checked next cycle
  } laneStrobe_t;

endpackage

// File: rtl/upper_lane_ctrl.sv
module upper_lane_ctrl
  import upper_lane_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        trdyN,
  input  logic        devselN,
  input  logic        gntN,
  input  logic        req64In,
  input  logic        ack64In,
  input  logic        isInit,
  input  logic        isTarget,
  input  logic        isWrite,
  input  logic        dualAddr,
  input  logic        localReq64,
  input  logic        localAck64,
  output laneStrobe_t strobe,
  output logic        req64Out,
  output logic        req64Oe,
  output logic        ack64Out,
  output logic        ack64Oe,
  output logic        wide64
);

  logic cap64;
  logic prevFrameN;
  logic dacQ;
  logic reqHeldQ;
  logic ackHeldQ;

  logic addrFirst, addrAny, busIdle, dataPh, wideData;
  logic reqAssert, ackAssert, parkNow, addrDrv;
  logic wrDrv, rdDrv, rxData;

  always_comb begin
    addrFirst = !frameN && prevFrameN;
    addrAny   = addrFirst || dacQ;
    busIdle   = frameN && irdyN;
    dataPh    = !addrAny && !busIdle;
    wideData  = !req64In && !ack64In;
    parkNow   = busIdle && !gntN;
    addrDrv   = isInit && localReq64 && addrAny;
    reqAssert = cap64 && isInit && localReq64 && !frameN;
    ackAssert = cap64 && isTarget && localAck64 && !devselN && !req64In;
    // owner of AD in a wide data phase
    wrDrv     = (isInit && isWrite) || (isTarget && !isWrite);
    // this port receives AD in a wide data phase
    rdDrv     = (isInit && !isWrite) || (isTarget && isWrite);
    rxData    = dataPh && wideData && !irdyN && !trdyN && rdDrv;
  end

  always_comb begin
    strobe.zeroLane = !cap64 || parkNow;
    strobe.drvAd    = rstN && (!cap64 || parkNow || addrDrv ||
                               (dataPh && wideData && wrDrv));
    strobe.drvCbe   = rstN && (!cap64 || parkNow || addrDrv ||
                               (dataPh && wideData && isInit));
    strobe.rxArm    = cap64 && ((isTarget && addrAny && !req64In) || rxData);
  end

  assign req64Out = !reqAssert;
  assign req64Oe  = rstN && (reqAssert || reqHeldQ);
  assign ack64Out = !ackAssert;
  assign ack64Oe  = rstN && (ackAssert || ackHeldQ);
  assign wide64   = cap64;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cap64      <= !req64In;   // strap sampled throughout reset
      prevFrameN <= 1'b1;
      dacQ       <= 1'b0;
      reqHeldQ   <= 1'b0;
      ackHeldQ   <= 1'b0;
    end else begin
      prevFrameN <= frameN;
      dacQ       <= addrFirst && dualAddr;
      reqHeldQ   <= reqAssert;
      ackHeldQ   <= ackAssert;
    end
  end

endmodule

// File: rtl/upper_lane_dp.sv
module upper_lane_dp
  import upper_lane_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobe_t       strobe,
  input  logic [LANE_W-1:0] txAd,
  input  logic [BE_W-1:0]   txCbe,
  input  logic [LANE_W-1:0] adIn,
  input  logic [BE_W-1:0]   cbeIn,
  input  logic              parIn,
  output logic [LANE_W-1:0] adOut,
  output logic              adOe,
  output logic [BE_W-1:0]   cbeOut,
  output logic              cbeOe,
  output logic              parOut,
  output logic              parOe,
  output logic              perr
);

  localparam int PAR_W = LANE_W + BE_W;

  logic [PAR_W-1:0] busWord;
  logic             busPar;
  logic             parQ;
  logic             parOeQ;
  logic             armQ;
  logic             perrQ;

  assign busWord = {adIn, cbeIn};
  assign busPar  = ^busWord;

  assign adOut  = strobe.zeroLane ? '0 : txAd;
  assign cbeOut = strobe.zeroLane ? '0 : txCbe;
  assign adOe   = strobe.drvAd;
  assign cbeOe  = strobe.drvCbe;
  assign parOut = parQ;
  assign parOe  = parOeQ;
  assign perr   = perrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parQ   <= 1'b0;
      parOeQ <= 1'b0;
      armQ   <= 1'b0;
      perrQ  <= 1'b0;
    end else begin
      parQ   <= busPar;
      parOeQ <= strobe.drvAd;
      armQ   <= strobe.rxArm;
      perrQ  <= armQ && (parIn != parQ);
    end
  end

endmodule

// File: rtl/upper_lane_top.sv
module upper_lane_top
  import upper_lane_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic              irdyN,
  input  logic              trdyN,
  input  logic              devselN,
  input  logic              gntN,
  input  logic              req64In,
  input  logic              ack64In,
  input  logic              isInit,
  input  logic              isTarget,
  input  logic              isWrite,
  input  logic              dualAddr,
  input  logic              localReq64,
  input  logic              localAck64,
  input  logic [LANE_W-1:0] txAd,
  input  logic [BE_W-1:0]   txCbe,
  input  logic [LANE_W-1:0] adIn,
  input  logic [BE_W-1:0]   cbeIn,
  input  logic              parIn,
  output logic [LANE_W-1:0] adOut,
  output logic              adOe,
  output logic [BE_W-1:0]   cbeOut,
  output logic              cbeOe,
  output logic              parOut,
  output logic              parOe,
  output logic              req64Out,
  output logic              req64Oe,
  output logic              ack64Out,
  output logic              ack64Oe,
  output logic              perr,
  output logic              wide64
);

  laneStrobe_t strobe;

  upper_lane_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .devselN(devselN), .gntN(gntN), .req64In(req64In), .ack64In(ack64In),
    .isInit(isInit), .isTarget(isTarget), .isWrite(isWrite),
    .dualAddr(dualAddr), .localReq64(localReq64), .localAck64(localAck64),
    .strobe(strobe), .req64Out(req64Out), .req64Oe(req64Oe),
    .ack64Out(ack64Out), .ack64Oe(ack64Oe), .wide64(wide64)
  );

  upper_lane_dp #(.LANE_W(LANE_W), .BE_W(BE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txAd(txAd), .txCbe(txCbe),
    .adIn(adIn), .cbeIn(cbeIn), .parIn(parIn), .adOut(adOut), .adOe(adOe),
    .cbeOut(cbeOut), .cbeOe(cbeOe), .parOut(parOut), .parOe(parOe),
    .perr(perr)
  );

endmodule

// File: rtl/upper_lane_chk.sv
module upper_lane_chk #(
  parameter int LANE_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameN,
  input logic              irdyN,
  input logic              gntN,
  input logic [LANE_W-1:0] adIn,
  input logic [BE_W-1:0]   cbeIn,
  input logic [LANE_W-1:0] adOut,
  input logic              adOe,
  input logic [BE_W-1:0]   cbeOut,
  input logic              cbeOe,
  input logic              parOut,
  input logic              parOe,
  input logic              req64Out,
  input logic              req64Oe,
  input logic              ack64Out,
  input logic              ack64Oe,
  input logic              wide64
);

  logic warm;
  always_ff @(posedge clk) begin
    if (!rstN) warm <= 1'b0;
    else       warm <= 1'b1;
  end

  // R2
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!adOe && !cbeOe && !req64Oe && !ack64Oe));

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> $stable(wide64));

  // R3
  par_oe_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (parOe == $past(adOe)));

  // R3
  par_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (parOut == ^$past({adIn, cbeIn})));

  // R4
  narrow_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wide64 |-> (adOe && cbeOe && adOut == '0 && cbeOut == '0 && !req64Oe && !ack64Oe));

  // R5
  park_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameN && irdyN && !gntN) |-> (adOe && cbeOe && adOut == '0 && cbeOut == '0));

  // R8
  req_release_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(req64Oe && !req64Out) && req64Out) |-> req64Oe);

  // R8
  req_release_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(req64Oe && req64Out) && req64Out) |-> !req64Oe);

  // R9
  ack_release_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(ack64Oe && !ack64Out) && ack64Out) |-> ack64Oe);

  // R9
  ack_release_float_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(ack64Oe && ack64Out) && ack64Out) |-> !ack64Oe);

endmodule

bind upper_lane_top upper_lane_chk #(.LANE_W(LANE_W), .BE_W(BE_W)) chk_i (.*);

// File: tb/upper_lane_top_tb_top.sv
module upper_lane_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANE_W     = 32;
  localparam int BE_W       = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN, frameN, irdyN, trdyN, devselN, gntN, req64In, ack64In;
  logic isInit, isTarget, isWrite, dualAddr, localReq64, localAck64, parIn;
  logic [LANE_W-1:0] txAd, adIn, adOut;
  logic [BE_W-1:0]   txCbe, cbeIn, cbeOut;
  logic adOe, cbeOe, parOut, parOe, req64Out, req64Oe, ack64Out, ack64Oe;
  logic perr, wide64;

  upper_lane_top #(.LANE_W(LANE_W), .BE_W(BE_W)) dut_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .devselN(devselN), .gntN(gntN), .req64In(req64In), .ack64In(ack64In),
    .isInit(isInit), .isTarget(isTarget), .isWrite(isWrite),
    .dualAddr(dualAddr), .localReq64(localReq64), .localAck64(localAck64),
    .txAd(txAd), .txCbe(txCbe), .adIn(adIn), .cbeIn(cbeIn), .parIn(parIn),
    .adOut(adOut), .adOe(adOe), .cbeOut(cbeOut), .cbeOe(cbeOe),
    .parOut(parOut), .parOe(parOe), .req64Out(req64Out), .req64Oe(req64Oe),
    .ack64Out(ack64Out), .ack64Oe(ack64Oe), .perr(perr), .wide64(wide64)
  );

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  // expected-state model, built from the requirements
  logic mCap, mPrevF, mDac, mReqQ, mAckQ, mParQ, mParOe, mArm, mPerr;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: check combinational outputs, step the model, check registered outputs
  task automatic cycle();
    logic eFirst, eAny, eIdle, eData, eWide, eReqA, eAckA, ePark, eAddrDrv;
    logic eAdOe, eCbeOe, eRx, eZero;
    logic [LANE_W-1:0] eAd;
    logic [BE_W-1:0]   eCbe;
    string tag;
    #1;
    eFirst   = !frameN && mPrevF;
    eAny     = eFirst || mDac;
    eIdle    = frameN && irdyN;
    eData    = !eAny && !eIdle;
    eWide    = !req64In && !ack64In;
    ePark    = eIdle && !gntN;
    eAddrDrv = isInit && localReq64 && eAny;
    eReqA    = mCap && isInit && localReq64 && !frameN;
    eAckA    = mCap && isTarget && localAck64 && !devselN && !req64In;
    eZero    = !mCap || ePark;
    eAdOe    = rstN && (!mCap || ePark || eAddrDrv ||
                        (eData && eWide && ((isInit && isWrite) || (isTarget && !isWrite))));
    eCbeOe   = rstN && (!mCap || ePark || eAddrDrv || (eData && eWide && isInit));
    eRx      = mCap && ((isTarget && eAny && !req64In) ||
                        (eData && eWide && !irdyN && !trdyN &&
                         ((isInit && !isWrite) || (isTarget && isWrite))));
    eAd      = eZero ? '0 : txAd;
    eCbe     = eZero ? '0 : txCbe;
    if (!rstN)      tag = "R2";
    else if (!mCap) tag = "R4";
    else if (ePark) tag = "R5";
    else if (eAny)  tag = "R6";
    else            tag = "R7";
    chk(tag, "adOe", 32'(adOe), 32'(eAdOe));
    chk(tag, "cbeOe", 32'(cbeOe), 32'(eCbeOe));
    if (eAdOe)  chk(tag, "adOut", adOut, eAd);
    if (eCbeOe) chk(tag, "cbeOut", 32'(cbeOut), 32'(eCbe));
    chk(rstN ? "R8" : "R2", "req64Oe", 32'(req64Oe), 32'(rstN && (eReqA || mReqQ)));
    if (rstN && (eReqA || mReqQ)) chk("R8", "req64Out", 32'(req64Out), 32'(!eReqA));
    chk(rstN ? "R9" : "R2", "ack64Oe", 32'(ack64Oe), 32'(rstN && (eAckA || mAckQ)));
    if (rstN && (eAckA || mAckQ)) chk("R9", "ack64Out", 32'(ack64Out), 32'(!eAckA));
    @(posedge clk);
    if (!rstN) begin
      mCap = !req64In; mPrevF = 1'b1; mDac = 1'b0; mReqQ = 1'b0; mAckQ = 1'b0;
      mParQ = 1'b0; mParOe = 1'b0; mArm = 1'b0; mPerr = 1'b0;
    end else begin
      mPerr  = mArm && (parIn != mParQ);
      mArm   = eRx;
      mParQ  = ^{adIn, cbeIn};
      mParOe = eAdOe;
      mDac   = eFirst && dualAddr;
      mPrevF = frameN;
      mReqQ  = eReqA;
      mAckQ  = eAckA;
    end
    @(negedge clk);
    chk("R3", "parOut", 32'(parOut), 32'(mParQ));
    chk(rstN ? "R3" : "R2", "parOe", 32'(parOe), 32'(mParOe));
    chk(rstN ? "R10" : "R2", "perr", 32'(perr), 32'(mPerr));
    chk("R1", "wide64", 32'(wide64), 32'(mCap));
  endtask

  task automatic randIn();
    frameN     = ($urandom % 3) == 0;
    irdyN      = ($urandom % 3) == 0;
    trdyN      = ($urandom % 3) == 0;
    devselN    = ($urandom % 3) == 0;
    gntN       = 1'($urandom % 2);
    req64In    = ($urandom % 4) == 0;
    ack64In    = ($urandom % 4) == 0;
    isInit     = 1'($urandom % 2);
    isTarget   = !isInit;
    isWrite    = 1'($urandom % 2);
    dualAddr   = ($urandom % 3) == 0;
    localReq64 = ($urandom % 4) != 0;
    localAck64 = ($urandom % 4) != 0;
    txAd       = $urandom;
    txCbe      = 4'($urandom);
    adIn       = $urandom;
    cbeIn      = 4'($urandom);
    parIn      = mParQ ^ 1'($urandom % 2);
  endtask

  task automatic doReset(logic strap);
    rstN = 1'b0;
    req64In = strap;
    repeat (3) cycle();
    rstN = 1'b1;
  endtask

  task automatic setBus(logic f, logic i, logic t, logic d, logic g, logic rq, logic ak);
    frameN = f; irdyN = i; trdyN = t; devselN = d; gntN = g; req64In = rq; ack64In = ak;
    adIn = $urandom; cbeIn = 4'($urandom); txAd = $urandom; txCbe = 4'($urandom);
  endtask

  initial begin
    void'($urandom(32'h1d2c3b4a));
    mCap = 1'b0; mPrevF = 1'b1; mDac = 1'b0; mReqQ = 1'b0; mAckQ = 1'b0;
    mParQ = 1'b0; mParOe = 1'b0; mArm = 1'b0; mPerr = 1'b0;
    rstN = 1'b0; frameN = 1'b1; irdyN = 1'b1; trdyN = 1'b1; devselN = 1'b1;
    gntN = 1'b1; req64In = 1'b1; ack64In = 1'b1; isInit = 1'b0; isTarget = 1'b0;
    isWrite = 1'b0; dualAddr = 1'b0; localReq64 = 1'b0; localAck64 = 1'b0;
    txAd = '0; txCbe = '0; adIn = '0; cbeIn = '0; parIn = 1'b0;
    @(negedge clk);

    // R1, R4: strap high selects the narrow mode, lanes stay driven at zero
    doReset(1'b1);
    for (int n = 0; n < 60; n++) begin randIn(); cycle(); end

    // R1: strap low enables wide operation
    doReset(1'b0);
    isInit = 1'b1; isTarget = 1'b0; isWrite = 1'b1; dualAddr = 1'b1;
    localReq64 = 1'b1; localAck64 = 1'b1;
    // R5: idle with grant parks lanes
    setBus(1, 1, 1, 1, 0, 1, 1); parIn = mParQ; cycle();
    // R6: first and second address phase of a dual-address write
    setBus(0, 1, 1, 1, 0, 0, 1); parIn = mParQ; cycle();
    setBus(0, 1, 1, 1, 0, 0, 1); parIn = mParQ; cycle();
    // R7: wide write data
    setBus(0, 0, 0, 0, 0, 0, 0); parIn = mParQ; cycle();
    // R8: last data phase with frame released, then release and float
    setBus(1, 0, 0, 0, 0, 0, 0); parIn = mParQ; cycle();
    setBus(1, 1, 1, 1, 1, 1, 1); parIn = mParQ; cycle();
    setBus(1, 1, 1, 1, 1, 1, 1); parIn = mParQ; cycle();

    // R9, R10: target receiving wide write data with a bad parity bit
    isInit = 1'b0; isTarget = 1'b1; dualAddr = 1'b0;
    setBus(0, 1, 1, 1, 1, 0, 1); parIn = mParQ; cycle();
    setBus(0, 0, 0, 0, 1, 0, 0); parIn = mParQ; cycle();
    setBus(1, 0, 0, 0, 1, 0, 0); parIn = !mParQ; cycle();
    setBus(1, 1, 1, 1, 1, 1, 1); parIn = !mParQ; cycle();
    setBus(1, 1, 1, 1, 1, 1, 1); parIn = mParQ; cycle();
    setBus(1, 1, 1, 1, 1, 1, 1); parIn = mParQ; cycle();

    // mixed random traffic in wide mode
    for (int n = 0; n < 3000; n++) begin randIn(); cycle(); end

    // R1: another reset returning to the narrow strap
    doReset(1'b1);
    for (int n = 0; n < 40; n++) begin randIn(); cycle(); end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule